// File: doc/BRIEF.md
# Single-Step Trace Trap Trigger

This block decides, once per retired instruction, whether the processor must take a single-step trace exception. It watches the retire stage through a valid strobe and two qualifiers (delayed branch, call), together with the current trace-enable and trace-pending status bits. It drives a registered trap request towards the exception sequencer.

Two rules gate the request. No trap ever follows a delayed-branch instruction. A retiring call opens a short suppression window: the call itself and the next retiring instruction (or the next `SHADOW_LEN` instructions) raise no trap, whatever the trace-enable bit says. The block only reads the trace-enable bit and never writes it. When another exception entry is in progress, an eligible request waits in a one-bit hold register and is issued once that entry has finished.

Top module: `step_trap_gate`

## Requirements
- R1: A synchronous active-high reset forces `trap_req` to 0 on the following cycle and clears both the call window and any waiting request. The first eligible retire after reset traps.
- R2: A retire with `trace_en`=1 and `trace_pend`=1, not a delayed branch, not a call, outside a call window and with `exc_busy`=0 makes `trap_req` 1 for exactly the next cycle. Back-to-back eligible retires give back-to-back pulses.
- R3: A retire with `trace_en`=0 or `trace_pend`=0 raises no trap. Both bits are sampled on the retire cycle itself, so a `trace_pend` value restored by a return governs the next decision.
- R4: A retire with `retire_dbr`=1 raises no trap.
- R5: A retire with `retire_call`=1 raises no trap on its own retire.
- R6: After a call retires, the next `SHADOW_LEN` retires (default 1) raise no trap, whatever `trace_en` is. Idle cycles do not shorten the window. A call inside the window restarts it.
- R7: While `exc_busy`=1, `trap_req` is 0 on the following cycle. An eligible retire seen meanwhile is kept, and several of them merge into one waiting request.
- R8: A waiting request is issued as a one-cycle `trap_req` pulse on the cycle after `exc_busy` is sampled at 0.
- R9: Cycles without a retire and with no waiting request leave `trap_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace-enable status bit (read only) |
| trace_pend | input | 1 | Trace-pending status bit |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_dbr | input | 1 | The retiring instruction is a delayed branch |
| retire_call | input | 1 | The retiring instruction is a call |
| exc_busy | input | 1 | Another exception entry is in progress |
| trap_req | output | 1 | Registered one-cycle trace trap request |

## Verification
The bench builds the block with the default `SHADOW_LEN` of 1. With that value the window after a call is exactly one retire, which is the boundary that matters here: the retire just after a call must stay silent and the one after that must trap. Idle gaps inside the window, a call that lands inside an open window, and a reset that arrives while a request is waiting behind `exc_busy` are also driven, because each of them puts the window counter or the hold bit in a state that a plain run of retires never reaches.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;

  typedef struct packed {
    logic vld;
    logic dbr;
    logic call;
  } retire_t;

  typedef struct packed {
    logic en;
    logic pend;
  } trace_bits_t;

endpackage

// File: rtl/step_shadow.sv
module step_shadow #(
  parameter int unsigned SHADOW_LEN = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  step_trap_pkg::retire_t ret,
  output logic                   shadow_act
);
  localparam int unsigned CW = (SHADOW_LEN < 1) ? 1 : $clog2(SHADOW_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(SHADOW_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ret.vld) begin
      if (ret.call)
        cnt_q <= LOAD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign shadow_act = (cnt_q != '0);
endmodule

// File: rtl/step_qualify.sv
module step_qualify (
  input  step_trap_pkg::retire_t     ret,
  input  step_trap_pkg::trace_bits_t tb,
  input  logic                       shadow_act,
  output logic                       eligible
);
  always_comb begin
    eligible = 1'b0;
    if (ret.vld && tb.en && tb.pend) begin
      eligible = !ret.dbr && !ret.call && !shadow_act;
    end
  end
endmodule

// File: rtl/step_req_reg.sv
module step_req_reg (
  input  logic clk,
  input  logic rst,
  input  logic eligible,
  input  logic exc_busy,
  output logic trap_req,
  output logic held
);
  logic want;

  assign want = eligible || held;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      held     <= 1'b0;
    end else begin
      trap_req <= want && !exc_busy;
      held     <= want && exc_busy;
    end
  end
endmodule

// File: rtl/step_trap_gate.sv
module step_trap_gate #(
  parameter int unsigned SHADOW_LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trace_en,
  input  logic trace_pend,
  input  logic retire_vld,
  input  logic retire_dbr,
  input  logic retire_call,
  input  logic exc_busy,
  output logic trap_req
);
  import step_trap_pkg::*;

  retire_t     ret;
  trace_bits_t tb;
  logic        shadow_act;
  logic        eligible;
  logic        held;

  assign ret = '{vld: retire_vld, dbr: retire_dbr, call: retire_call};
  assign tb  = '{en: trace_en, pend: trace_pend};

  step_shadow #(.SHADOW_LEN(SHADOW_LEN)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .ret        (ret),
    .shadow_act (shadow_act)
  );

  step_qualify u_qual (
    .ret        (ret),
    .tb         (tb),
    .shadow_act (shadow_act),
    .eligible   (eligible)
  );

  step_req_reg u_req (
    .clk      (clk),
    .rst      (rst),
    .eligible (eligible),
    .exc_busy (exc_busy),
    .trap_req (trap_req),
    .held     (held)
  );
endmodule

// File: rtl/step_trap_gate_chk.sv
module step_trap_gate_chk (
  input logic clk,
  input logic rst,
  input logic trace_en,
  input logic trace_pend,
  input logic retire_vld,
  input logic retire_dbr,
  input logic retire_call,
  input logic exc_busy,
  input logic trap_req,
  input logic shadow_act,
  input logic held
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !trap_req && !held && !shadow_act);

  // R2
  a_r2_eligible_traps: assert property (@(posedge clk) disable iff (rst)
    retire_vld && trace_en && trace_pend && !retire_dbr && !retire_call
    && !shadow_act && !exc_busy |=> trap_req);

  // R3
  a_r3_needs_both_bits: assert property (@(posedge clk) disable iff (rst)
    retire_vld && !(trace_en && trace_pend) && !held |=> !trap_req);

  // R4
  a_r4_no_trap_dbr: assert property (@(posedge clk) disable iff (rst)
    retire_vld && retire_dbr && !held |=> !trap_req);

  // R5
  a_r5_no_trap_call: assert property (@(posedge clk) disable iff (rst)
    retire_vld && retire_call && !held |=> !trap_req);

  // R6
  a_r6_window_silent: assert property (@(posedge clk) disable iff (rst)
    retire_vld && shadow_act && !held |=> !trap_req);

  a_r6_call_opens_window: assert property (@(posedge clk) disable iff (rst)
    retire_vld && retire_call |=> shadow_act);

  // R7
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    exc_busy |=> !trap_req);

  // R8
  a_r8_held_released: assert property (@(posedge clk) disable iff (rst)
    held && !exc_busy |=> trap_req && !held);

  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !retire_vld && !held |=> !trap_req);
endmodule

bind step_trap_gate step_trap_gate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .trace_en    (trace_en),
  .trace_pend  (trace_pend),
  .retire_vld  (retire_vld),
  .retire_dbr  (retire_dbr),
  .retire_call (retire_call),
  .exc_busy    (exc_busy),
  .trap_req    (trap_req),
  .shadow_act  (shadow_act),
  .held        (held)
);

// File: tb/step_trap_gate_bench.sv
module step_trap_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHADOW_LEN = 1;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trace_en = 1'b0, trace_pend = 1'b0;
  logic retire_vld = 1'b0, retire_dbr = 1'b0, retire_call = 1'b0;
  logic exc_busy = 1'b0;
  logic trap_req;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  int   m_shadow = 0;
  bit   m_held = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_trap_gate #(.SHADOW_LEN(SHADOW_LEN)) u_step_trap_gate (
    .clk         (clk),
    .rst         (rst),
    .trace_en    (trace_en),
    .trace_pend  (trace_pend),
    .retire_vld  (retire_vld),
    .retire_dbr  (retire_dbr),
    .retire_call (retire_call),
    .exc_busy    (exc_busy),
    .trap_req    (trap_req)
  );

  // One cycle of stimulus plus the expected trap_req after the next edge.
  task automatic cyc(input bit r, input bit ret, input bit t, input bit p,
                     input bit dbr, input bit call, input bit busy,
                     input string tag);
    bit elig, want, e;
    @(negedge clk);
    rst = r; retire_vld = ret; trace_en = t; trace_pend = p;
    retire_dbr = dbr; retire_call = call; exc_busy = busy;
    if (r) begin
      e = 1'b0; m_held = 1'b0; m_shadow = 0;
    end else begin
      elig = ret && t && p && !dbr && !call && (m_shadow == 0);
      want = elig || m_held;
      e = want && !busy;
      m_held = want && busy;
      if (ret) begin
        if (call) m_shadow = SHADOW_LEN;
        else if (m_shadow > 0) m_shadow--;
      end
    end
    sb.push_back('{val: e, tag: tag});
  endtask

  // Monitor: compares just after each edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (trap_req !== x.val) begin
        errors++;
        $display("FAIL %s: trap_req=%b expected=%b at %0t", x.tag, trap_req, x.val, $time);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    cyc(1,0,0,0,0,0,0,"R1");
    cyc(1,1,1,1,0,0,0,"R1");
    cyc(0,1,1,1,0,0,0,"R1");
    // R9 idle
    cyc(0,0,1,1,0,0,0,"R9");
    cyc(0,0,1,1,0,0,0,"R9");
    // R3 enables
    cyc(0,1,0,1,0,0,0,"R3");
    cyc(0,1,1,0,0,0,0,"R3");
    cyc(0,1,0,0,0,0,0,"R3");
    cyc(0,1,1,1,0,0,0,"R3");
    // R4 delayed branch
    cyc(0,1,1,1,1,0,0,"R4");
    // R2 back-to-back
    cyc(0,1,1,1,0,0,0,"R2");
    cyc(0,1,1,1,0,0,0,"R2");
    // R5 call, R6 window
    cyc(0,1,1,1,0,1,0,"R5");
    cyc(0,1,1,1,0,0,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    // R6 idle gap inside window
    cyc(0,1,1,1,0,1,0,"R5");
    cyc(0,0,1,1,0,0,0,"R6");
    cyc(0,0,1,1,0,0,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    // R6 call with trace off still opens window
    cyc(0,1,0,0,0,1,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    // R6 call inside window restarts it
    cyc(0,1,1,1,0,1,0,"R6");
    cyc(0,1,1,1,0,1,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    cyc(0,1,1,1,0,0,0,"R6");
    // R7 busy holds, R8 release
    cyc(0,1,1,1,0,0,1,"R7");
    cyc(0,0,0,0,0,0,1,"R7");
    cyc(0,1,1,1,0,0,1,"R7");
    cyc(0,0,0,0,0,0,0,"R8");
    cyc(0,0,0,0,0,0,0,"R8");
    // R8 release together with a new eligible retire merges
    cyc(0,1,1,1,0,0,1,"R7");
    cyc(0,1,1,1,0,0,0,"R8");
    cyc(0,0,0,0,0,0,0,"R8");
    // R1 reset drops a waiting request
    cyc(0,1,1,1,0,0,1,"R7");
    cyc(1,0,0,0,0,0,0,"R1");
    cyc(0,0,0,0,0,0,0,"R1");
    cyc(0,0,0,0,0,0,0,"R1");
    // R3 pend cleared by handler then restored
    cyc(0,1,1,0,0,0,0,"R3");
    cyc(0,1,1,1,0,0,0,"R3");
    cyc(0,0,0,0,0,0,0,"R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule